// File: doc/BRIEF.md
# Cascaded Reload Timer with Pulse and Event Modes

This block is an 8-bit down-counting prescaler feeding an 8-bit down-counting timer. Each counter has a reload latch. A register write to a counter sets both its latch and its live count in the same cycle. A counter that holds zero underflows on its next count pulse and then reloads from its latch. A reload value of n therefore divides by n+1. The timer counts prescaler underflows, so the pair divides the count source by (n+1)(m+1).

The count source depends on the mode:
- **Timer mode** uses a one-cycle enable tick that the surrounding clock logic supplies.
- **Event counter mode** uses the rising or falling edges of an external pin, which is first synchronised through two flops.

Every timer underflow raises an interrupt request flag, and the flag stays set until it is cleared. In pulse output mode the primary output inverts on each timer underflow. An optional second output then carries the inverse of that waveform.

All logic runs on one clock with an active-low asynchronous reset.

Top module: `tmr_cascade_timer`

## Requirements
- R1: A write with `wr_sel_i` = 0 (prescaler) or 1 (timer) stores `wr_data_i` in that counter's latch and its live count at the same clock edge. Later reloads use the written value.
- R2: `rd_data_o` is combinational from `rd_sel_i`:
  - 0 gives the live prescaler count.
  - 1 gives the live timer count.
  - 2 gives the mode register {4'b0, inv_en, edge_sel, mode[1:0]}.
  - 3 gives zero.
- R3: On each count pulse the prescaler decrements. A count pulse while it holds 0 reloads it from its latch and produces one prescaler underflow, so reload value n divides by n+1.
- R4: The timer changes only on a prescaler underflow or on its own write. It follows the same reload rule, so the cascade yields exactly floor(K/((n+1)(m+1))) timer underflows after K count pulses.
- R5: A timer underflow sets `irq_o`. `irq_o` stays set until `irq_clr_i` is high, and a set in the same cycle as a clear wins.
- R6: Mode register fields (written with `wr_sel_i` = 2):
  - Bits [1:0] select the mode: 0 timer, 1 pulse output, 2 event counter, 3 reserved.
  - Bit 2 is the edge-select bit.
  - Bit 3 enables the inverted output.
  - Reserved mode 3 behaves exactly as timer mode.
- R7: In pulse output mode `pulse_o` inverts on every timer underflow. In the other modes it holds its level.
- R8: Any mode register write sets `pulse_o` to the inverse of the new edge-select bit: high for 0, low for 1. Reset leaves `pulse_o` high.
- R9: `pulse_n_o` equals the inverse of `pulse_o` when the inverted-output enable bit is 1, and is 0 otherwise.
- R10: In event counter mode the prescaler counts rising edges of `ext_pin_i` when edge-select is 0 and falling edges when it is 1, and `tick_i` is ignored. In the other modes pin edges are ignored.
- R11: When a counter write and that counter's underflow fall in the same cycle, the written value wins for both count and latch, and no underflow is produced.
- R12: After reset:
  - Both counts and both latches are 0xFF.
  - The mode register is 0.
  - `irq_o` is 0, `pulse_o` is 1 and `pulse_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal count-enable tick |
| ext_pin_i | input | 1 | External event input, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 prescaler, 1 timer, 2 mode |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read source select |
| rd_data_o | output | 8 | Read data |
| irq_clr_i | input | 1 | Clears the interrupt request flag |
| irq_o | output | 1 | Interrupt request flag |
| pulse_o | output | 1 | Pulse output waveform |
| pulse_n_o | output | 1 | Inverted pulse output when enabled |

## Verification
The assertions check the following on every cycle:
- every prescaler reload lands on the latch value;
- the timer moves only on an underflow or a write;
- the flag rises after every underflow and holds until cleared;
- the pulse level is still when there is neither an underflow nor a mode write;
- a written value always lands in the count.

The bench's scenarios cover the rest:
- the exact division ratios over a sweep of reload pairs;
- the starting levels tied to the edge-select bit;
- the rising versus falling pin selection through the synchroniser;
- the fact that reserved mode matches timer mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W    = 8;
  localparam int SEL_W    = 2;
  localparam int EDGE_BIT = 2;
  localparam int INV_BIT  = 3;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_RSVD  = 2'd3
  } tmr_mode_e;

  localparam logic [SEL_W-1:0] SEL_PRE  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_TMR  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MODE = 2'd2;

  // choose the counted edge: 0 -> rising, 1 -> falling
  function automatic logic pick_edge(input logic fall_sel, input logic rise, input logic fall);
    return fall_sel ? fall : rise;
  endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o =  chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/tmr_down_stage.sv
module tmr_down_stage #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         cnt_en_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] latch_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, latch_q;

  function automatic logic [W-1:0] next_down(input logic [W-1:0] cur, input logic [W-1:0] rel);
    return (cur == '0) ? rel : cur - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_VAL;
      latch_q <= RST_VAL;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      latch_q <= load_val_i;
    end else if (cnt_en_i) begin
      cnt_q   <= next_down(cnt_q, latch_q);
    end
  end

  assign uf_o    = cnt_en_i && !load_i && (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/tmr_pulse_out.sv
module tmr_pulse_out (
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic init_lvl_i,
  input  logic toggle_i,
  output logic lvl_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_q <= 1'b1;
    else if (init_i)   lvl_q <= init_lvl_i;
    else if (toggle_i) lvl_q <= ~lvl_q;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/tmr_cascade_timer.sv
module tmr_cascade_timer
  import tmr_pkg::*;
#(
  parameter int W        = tmr_pkg::CNT_W,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         ext_pin_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  input  logic         irq_clr_i,
  output logic         irq_o,
  output logic         pulse_o,
  output logic         pulse_n_o
);
  localparam int MODE_REG_W = INV_BIT + 1;

  // named internal events
  logic         wr_pre, wr_tmr, mode_wr;
  logic         pin_rise, pin_fall;
  logic         pre_pulse, pre_uf, tmr_uf, pulse_toggle;
  logic [W-1:0] pre_cnt, pre_latch, tmr_cnt, tmr_latch;

  tmr_mode_e mode_q;
  logic      edge_q, inv_q, irq_q;

  assign wr_pre  = wr_en_i && (wr_sel_i == SEL_PRE);
  assign wr_tmr  = wr_en_i && (wr_sel_i == SEL_TMR);
  assign mode_wr = wr_en_i && (wr_sel_i == SEL_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TIMER;
      edge_q <= 1'b0;
      inv_q  <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= tmr_mode_e'(wr_data_i[1:0]);
      edge_q <= wr_data_i[EDGE_BIT];
      inv_q  <= wr_data_i[INV_BIT];
    end
  end

  tmr_sync_edge #(.STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign pre_pulse = (mode_q == MODE_EVENT) ? pick_edge(edge_q, pin_rise, pin_fall) : tick_i;

  tmr_down_stage #(.W(W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wr_pre),
    .load_val_i(wr_data_i),
    .cnt_en_i  (pre_pulse),
    .cnt_o     (pre_cnt),
    .latch_o   (pre_latch),
    .uf_o      (pre_uf)
  );

  tmr_down_stage #(.W(W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wr_tmr),
    .load_val_i(wr_data_i),
    .cnt_en_i  (pre_uf),
    .cnt_o     (tmr_cnt),
    .latch_o   (tmr_latch),
    .uf_o      (tmr_uf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (tmr_uf)    irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign pulse_toggle = tmr_uf && (mode_q == MODE_PULSE);

  tmr_pulse_out u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (mode_wr),
    .init_lvl_i(~wr_data_i[EDGE_BIT]),
    .toggle_i  (pulse_toggle),
    .lvl_o     (pulse_o)
  );

  assign pulse_n_o = inv_q ? ~pulse_o : 1'b0;
  assign irq_o     = irq_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      SEL_PRE:  rd_data_o = pre_cnt;
      SEL_TMR:  rd_data_o = tmr_cnt;
      SEL_MODE: rd_data_o[MODE_REG_W-1:0] = {inv_q, edge_q, mode_q};
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_cascade_timer_chk.sv
module tmr_cascade_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en_i,
  input logic [1:0]   wr_sel_i,
  input logic [W-1:0] wr_data_i,
  input logic         irq_clr_i,
  input logic         pre_uf,
  input logic         tmr_uf,
  input logic         mode_wr,
  input logic [W-1:0] pre_cnt,
  input logic [W-1:0] pre_latch,
  input logic [W-1:0] tmr_cnt,
  input logic [W-1:0] tmr_latch,
  input logic         irq_o,
  input logic         pulse_o
);
  logic wr_p, wr_t;
  assign wr_p = wr_en_i && (wr_sel_i == 2'd0);
  assign wr_t = wr_en_i && (wr_sel_i == 2'd1);

  AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pre_uf |=> (pre_cnt == $past(pre_latch)));                         // R3
  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_uf |=> (tmr_cnt == $past(tmr_latch)));                         // R4
  AST_TMR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_uf && !wr_t) |=> $stable(tmr_cnt));                          // R4
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_uf |=> irq_o);                                                 // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);                                  // R5
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_uf && !mode_wr) |=> $stable(pulse_o));                       // R7
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |=> (pre_cnt == $past(wr_data_i) && pre_latch == $past(wr_data_i))); // R11
  AST_NO_UF_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |-> !pre_uf);                                                 // R11
endmodule

bind tmr_cascade_timer tmr_cascade_timer_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en_i  (wr_en_i),
  .wr_sel_i (wr_sel_i),
  .wr_data_i(wr_data_i),
  .irq_clr_i(irq_clr_i),
  .pre_uf   (pre_uf),
  .tmr_uf   (tmr_uf),
  .mode_wr  (mode_wr),
  .pre_cnt  (pre_cnt),
  .pre_latch(pre_latch),
  .tmr_cnt  (tmr_cnt),
  .tmr_latch(tmr_latch),
  .irq_o    (irq_o),
  .pulse_o  (pulse_o)
);

// File: tb/tmr_cascade_timer_tb_top.sv
`timescale 1ns/1ps
module tmr_cascade_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, ext_pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [1:0] rd_sel_i = 2'd0;
  logic [7:0] rd_data_o;
  logic       irq_clr_i = 1'b0;
  logic       irq_o, pulse_o, pulse_n_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tmr_cascade_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_pin_i(ext_pin_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_clr_i(irq_clr_i),
    .irq_o(irq_o), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    rd_sel_i = sel; #1; v = rd_data_o;
  endtask

  task automatic tick1();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk); ext_pin_i = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_tests++;
    $display("FAIL R12 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd(2'd0, v); check("R12 pre reset", v, 255);
    rd(2'd1, v); check("R12 tmr reset", v, 255);
    rd(2'd2, v); check("R12 mode reset", v, 0);
    check("R12 irq reset", irq_o, 0);
    check("R12 pulse reset", pulse_o, 1);
    check("R12 pulse_n reset", pulse_n_o, 0);
    rd(2'd3, v); check("R2 sel3 zero", v, 0);

    // R1 R2 R3 R4 R5 R7: sweep reload pairs in pulse mode
    for (int n = 0; n < 4; n++) begin
      for (int m = 0; m < 4; m++) begin
        wr(2'd2, 8'h01);
        wr(2'd0, 8'(n));
        wr(2'd1, 8'(m));
        clr_irq();
        rd(2'd0, v); check("R1 pre load", v, n);
        rd(2'd1, v); check("R1 tmr load", v, m);
        for (int k = 1; k <= 2*(n+1)*(m+1)+1; k++) begin
          int p, u;
          tick1();
          p = k / (n+1);
          u = p / (m+1);
          rd(2'd0, v); check("R3 pre count", v, n - (k % (n+1)));
          rd(2'd1, v); check("R4 tmr count", v, m - (p % (m+1)));
          check("R5 irq", irq_o, (u > 0) ? 1 : 0);
          check("R7 pulse", pulse_o, 1 ^ (u & 1));
        end
      end
    end

    // R5 clear, and set wins over clear
    clr_irq(); check("R5 clear", irq_o, 0);
    wr(2'd0, 8'd0); wr(2'd1, 8'd0);
    @(negedge clk); tick_i = 1'b1; irq_clr_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; irq_clr_i = 1'b0;
    check("R5 set beats clear", irq_o, 1);

    // R6 reserved mode and timer mode: count, no toggle
    for (int md = 0; md < 4; md += 3) begin
      wr(2'd2, 8'(md));
      rd(2'd2, v); check("R2 mode readback", v, md);
      wr(2'd0, 8'd0); wr(2'd1, 8'd0); clr_irq();
      tick1();
      check("R6 counts irq", irq_o, 1);
      check("R6 no toggle", pulse_o, 1);
    end

    // R8 R9 initial level and inverted output
    wr(2'd2, 8'h05); check("R8 edge1 low", pulse_o, 0);
    check("R9 disabled", pulse_n_o, 0);
    wr(2'd0, 8'd0); wr(2'd1, 8'd0); tick1();
    check("R7 toggle edge1", pulse_o, 1);
    wr(2'd2, 8'h0D); check("R8 rewrite low", pulse_o, 0);
    check("R9 inverted", pulse_n_o, 1);
    wr(2'd2, 8'h09); check("R8 edge0 high", pulse_o, 1);
    check("R9 inverted hi", pulse_n_o, 0);

    // R11 write beats underflow
    wr(2'd2, 8'h00); wr(2'd0, 8'd0); wr(2'd1, 8'd0); clr_irq();
    @(negedge clk); tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'd7;
    @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
    rd(2'd0, v); check("R11 write wins", v, 7);
    rd(2'd1, v); check("R11 no tmr step", v, 0);
    check("R11 no irq", irq_o, 0);
    tick1(); tick1(); tick1(); tick1(); tick1(); tick1(); tick1(); tick1();
    rd(2'd0, v); check("R11 latch written", v, 7);

    // R10 timer mode ignores pin
    wr(2'd0, 8'd5);
    pin_to(1'b1); pin_to(1'b0);
    rd(2'd0, v); check("R10 pin ignored timer", v, 5);
    // R10 event rising
    wr(2'd2, 8'h02); wr(2'd0, 8'd5);
    tick1(); tick1();
    rd(2'd0, v); check("R10 tick ignored event", v, 5);
    pin_to(1'b1); rd(2'd0, v); check("R10 rising counted", v, 4);
    pin_to(1'b0); rd(2'd0, v); check("R10 falling skipped", v, 4);
    // R10 event falling
    wr(2'd2, 8'h06); wr(2'd0, 8'd5);
    pin_to(1'b1); rd(2'd0, v); check("R10 rising skipped", v, 5);
    pin_to(1'b0); rd(2'd0, v); check("R10 falling counted", v, 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule